// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a memory-mapped controller for a configurable number of general-purpose pins. The pins are split into banks of 32, and every control array spends one 32-bit word on each bank. Software reaches the arrays through a plain synchronous register bus. Through them it sets each pin's role and output level and reads back the sampled pad levels. It also chooses which edge raises an interrupt and services the pending interrupt flags.

Each pad input passes through a two-stage synchronizer. A third register holds the previous synchronized sample, and comparing the two reveals a rising or falling edge. When the pin is enabled and unmasked, a qualifying edge sets a sticky status flag. A single interrupt line stays high while any status flag is set on a pin whose mask bit is clear.

A build parameter removes the edge-type array. In that build the pending flags follow a high input level instead of an edge.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: The byte address is `(array * 2^BW + bank) * 4`, where BW = max(1, clog2(banks)), so that with 40 pins array a, bank b sits at byte `8a + 4b`. Pin n lives in bank n/32 at bit n%32. Array codes: 0 enable, 1 output data, 2 direction, 3 input level (read only), 4 mask, 5 status, 6 edge type. Read data appears on `bus_rdata` in the cycle after the read request. Array code 7 reads as zero.
- R2: After reset the state is as follows: every pin disabled and set to input, every mask bit 1, all status 0, edge types 0, output data 0, `pad_oe` 0 and `irq` 0.
- R3: `pad_out` follows the output-data bits. `pad_oe` for a pin is 1 only when its direction bit is 0 (output) and its enable bit is 1.
- R4: The input-level array returns each pad's level after two clock edges of synchronization, whatever the pin's direction. A read issued in the same cycle as a pad change still returns the old level.
- R5: A mask bit of 1 stops its pin from setting status. `irq` is 1 exactly when some status bit is 1 and its mask bit is 0, so masking or unmasking a pending pin changes `irq` without a new edge.
- R6: An edge-type bit of 1 selects rising edges and 0 selects falling edges. After a qualifying pad change, status and `irq` become 1 at the third rising clock edge, and not before.
- R7: A write to the status array clears each bit written as 0 and keeps each bit written as 1.
- R8: A pin whose enable bit is 0 never sets status.
- R9: In the last bank, bits at or above the pin count read as 0 in every array, and writing them has no effect.
- R10: When `EDGE_EN` is 0, status sets while the synchronized input is high and re-sets after a clear while the input stays high. The edge-type array then reads as 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| pad_in | input | NPINS | Pad input levels |
| pad_out | output | NPINS | Pad output values |
| pad_oe | output | NPINS | Pad output enables |
| irq | output | 1 | Combined interrupt |

## Verification
A bad synchronizer depth or a bad edge-history register shows up on `irq` one cycle early or late relative to the third edge after a pad change. It also makes a same-cycle level read return the new value. A decode fault in the per-pin write logic shows up on the next read of the affected word, on the wrong bank or at a spare bit position. A wrong status set/clear priority appears at once on `irq`: the line sits high after a clear, or a masked or disabled pin reaches it. In the level-only build, a fault shows as a cleared flag that fails to come back while the input stays high.

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl #(
  parameter int NPINS   = 40,
  parameter int ADDR_W  = 8,
  parameter bit EDGE_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic              irq
);
  localparam int NBANK  = (NPINS + 31) / 32;
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1;
  localparam int ARR_LO = 2 + BANK_W;
  localparam int ARR_W  = ADDR_W - ARR_LO;
  localparam int WIDE   = NBANK * 32;

  localparam int A_EN  = 0;
  localparam int A_WD  = 1;
  localparam int A_DIR = 2;
  localparam int A_LVL = 3;
  localparam int A_MSK = 4;
  localparam int A_STS = 5;
  localparam int A_EDG = 6;

  logic [ARR_W-1:0]  arr;
  logic [BANK_W-1:0] bank;
  assign arr  = bus_addr[ADDR_W-1:ARR_LO];
  assign bank = bus_addr[ARR_LO-1:2];

  logic [NPINS-1:0] en_q, wd_q, dir_q, msk_q, sts_q, edg_q;
  logic [NPINS-1:0] s1_q, s2_q, s3_q, evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= pad_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    localparam int B = i / 32;
    localparam int K = i % 32;
    logic bhit, set;
    assign bhit = bus_sel && bus_wr && (int'(bank) == B);
    assign set  = evt[i] && en_q[i] && !msk_q[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_q[i]  <= 1'b0;
        wd_q[i]  <= 1'b0;
        dir_q[i] <= 1'b1;
        msk_q[i] <= 1'b1;
        sts_q[i] <= 1'b0;
      end else begin
        if (bhit && int'(arr) == A_EN)  en_q[i]  <= bus_wdata[K];
        if (bhit && int'(arr) == A_WD)  wd_q[i]  <= bus_wdata[K];
        if (bhit && int'(arr) == A_DIR) dir_q[i] <= bus_wdata[K];
        if (bhit && int'(arr) == A_MSK) msk_q[i] <= bus_wdata[K];
        if (bhit && int'(arr) == A_STS) sts_q[i] <= (sts_q[i] & bus_wdata[K]) | set;
        else                            sts_q[i] <= sts_q[i] | set;
      end
    end

    if (EDGE_EN) begin : g_edge
      always_ff @(posedge clk) begin
        if (!rst_n)                          edg_q[i] <= 1'b0;
        else if (bhit && int'(arr) == A_EDG) edg_q[i] <= bus_wdata[K];
      end
      assign evt[i] = edg_q[i] ? (s2_q[i] & ~s3_q[i]) : (~s2_q[i] & s3_q[i]);
    end else begin : g_level
      assign edg_q[i] = 1'b0;
      assign evt[i]   = s2_q[i];
    end
  end

  assign pad_out = wd_q;
  assign pad_oe  = en_q & ~dir_q;
  assign irq     = |(sts_q & ~msk_q);

  logic [NPINS-1:0] pick;
  logic [WIDE-1:0]  pick_w;
  logic [31:0]      word;

  always_comb begin
    case (int'(arr))
      A_EN:    pick = en_q;
      A_WD:    pick = wd_q;
      A_DIR:   pick = dir_q;
      A_LVL:   pick = s2_q;
      A_MSK:   pick = msk_q;
      A_STS:   pick = sts_q;
      A_EDG:   pick = edg_q;
      default: pick = '0;
    endcase
    pick_w = WIDE'(pick);
    word   = '0;
    for (int b = 0; b < NBANK; b++)
      if (int'(bank) == b) word = pick_w[b*32 +: 32];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 bus_rdata <= '0;
    else if (bus_sel && !bus_wr) bus_rdata <= word;
  end

  logic unused_bits;
  assign unused_bits = &{1'b0, bus_addr[1:0], s3_q};
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
  parameter int NPINS  = 40,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              irq,
  input logic [NPINS-1:0]  en_q,
  input logic [NPINS-1:0]  msk_q,
  input logic [NPINS-1:0]  sts_q
);
  localparam int NBANK  = (NPINS + 31) / 32;
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1;
  localparam int REM    = NPINS % 32;

  a_r2_clean_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (sts_q == '0 && en_q == '0 && !irq));

  a_r8_disabled_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts_q & ~$past(sts_q)) & ~$past(en_q)) == '0);

  a_r5_masked_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts_q & ~$past(sts_q)) & $past(msk_q)) == '0);

  a_r5_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (sts_q != '0));

  if (REM != 0) begin : g_spare
    logic last_sts_rd;
    assign last_sts_rd = bus_sel && !bus_wr &&
                         (int'(bus_addr[ADDR_W-1:2+BANK_W]) == 5) &&
                         (int'(bus_addr[1+BANK_W:2]) == NBANK-1);
    a_r9_spare_status_zero: assert property (@(posedge clk) disable iff (!rst_n)
      last_sts_rd |=> (bus_rdata[31:REM] == '0));
  end
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .irq(irq),
  .en_q(en_q), .msk_q(msk_q), .sts_q(sts_q)
);

// File: tb/gpio_bank_ctrl_tb.sv
module gpio_bank_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, lvl_rdata;
  logic [NP-1:0] pad_in = '0, lvl_pad = '0;
  logic [NP-1:0] pad_out, pad_oe, lvl_out, lvl_oe;
  logic irq, lvl_irq;
  int checks = 0, errors = 0;
  logic [31:0] rv, lv;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank_ctrl #(.NPINS(NP), .ADDR_W(8), .EDGE_EN(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq));

  gpio_bank_ctrl #(.NPINS(NP), .ADDR_W(8), .EDGE_EN(1'b0)) u_lvl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(lvl_rdata),
    .pad_in(lvl_pad), .pad_out(lvl_out), .pad_oe(lvl_oe), .irq(lvl_irq));

  function automatic logic [7:0] ad(int a, int b);
    return 8'((a * 2 + b) * 4);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int a, int b, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = ad(a, b); bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(int a, int b);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = ad(a, b);
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0;
    rv = bus_rdata; lv = lvl_rdata;
  endtask

  task automatic t_reset;
    chk("R2 pad_oe", 64'(pad_oe), 0);
    chk("R2 irq", 64'(irq), 0);
    rd(0, 0); chk("R2 enable", 64'(rv), 0);
    rd(2, 0); chk("R2 dir bank0", 64'(rv), 64'hFFFF_FFFF);
    rd(2, 1); chk("R2 R9 dir bank1", 64'(rv), 64'h0000_00FF);
    rd(4, 1); chk("R2 mask bank1", 64'(rv), 64'h0000_00FF);
    rd(5, 0); chk("R2 status", 64'(rv), 0);
    rd(6, 0); chk("R2 edge", 64'(rv), 0);
  endtask

  task automatic t_output;
    wr(2, 0, ~32'hF);
    wr(1, 0, 32'h5);
    chk("R3 oe while disabled", 64'(pad_oe), 0);
    wr(0, 0, 32'hF);
    chk("R3 oe", 64'(pad_oe[3:0]), 64'hF);
    chk("R3 out", 64'(pad_out[3:0]), 64'h5);
    wr(0, 0, 32'hD);
    chk("R3 oe after release", 64'(pad_oe[3:0]), 64'hD);
    rd(1, 0); chk("R1 wdata readback", 64'(rv), 64'h5);
  endtask

  task automatic t_level;
    @(negedge clk);
    pad_in = 40'hA5_1234_5678;
    rd(3, 0); chk("R4 same-cycle read old", 64'(rv), 0);
    rd(3, 0); chk("R4 level bank0", 64'(rv), 64'h1234_5678);
    rd(3, 1); chk("R4 level bank1", 64'(rv), 64'hA5);
    @(negedge clk);
    pad_in = '0;
    repeat (4) @(posedge clk);
    rd(7, 0); chk("R1 unknown array", 64'(rv), 0);
  endtask

  task automatic t_edges;
    wr(0, 0, 32'h20); wr(0, 1, 32'h10);
    wr(4, 0, ~32'h20); wr(4, 1, ~32'h10);
    wr(6, 1, 32'h10);
    pad_in[5] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R6 rising ignored on falling pin", 64'(irq), 0);
    pad_in[36] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R6 not before third edge", 64'(irq), 0);
    @(posedge clk);
    @(negedge clk);
    chk("R6 irq at third edge", 64'(irq), 1);
    rd(5, 1); chk("R6 R1 status bank1", 64'(rv), 64'h10);
    wr(5, 1, ~32'h10);
    chk("R7 irq cleared", 64'(irq), 0);
    rd(5, 1); chk("R7 status cleared", 64'(rv), 0);
    pad_in[5] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R6 falling edge irq", 64'(irq), 1);
    wr(5, 0, 32'hFFFF_FFFF);
    rd(5, 0); chk("R7 ones keep", 64'(rv), 64'h20);
    wr(4, 0, 32'hFFFF_FFFF);
    chk("R5 mask hides irq", 64'(irq), 0);
    rd(5, 0); chk("R5 status held under mask", 64'(rv), 64'h20);
    wr(4, 0, ~32'h20);
    chk("R5 unmask shows irq", 64'(irq), 1);
    wr(5, 0, 32'h0);
    chk("R7 clear all", 64'(irq), 0);
  endtask

  task automatic t_blocked;
    wr(0, 0, 32'h40);
    wr(4, 0, ~32'h80);
    pad_in[6] = 1'b1; pad_in[7] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    pad_in[6] = 1'b0; pad_in[7] = 1'b0;
    repeat (4) @(posedge clk);
    rd(5, 0); chk("R5 R8 masked and disabled no status", 64'(rv), 0);
    chk("R5 R8 no irq", 64'(irq), 0);
  endtask

  task automatic t_spare;
    wr(0, 1, 32'hFFFF_FFFF); rd(0, 1); chk("R9 enable", 64'(rv), 64'hFF);
    wr(1, 1, 32'hFFFF_FFFF); rd(1, 1); chk("R9 wdata", 64'(rv), 64'hFF);
    wr(6, 1, 32'hFFFF_FFFF); rd(6, 1); chk("R9 edge", 64'(rv), 64'hFF);
    wr(5, 1, 32'hFFFF_FFFF); rd(5, 1); chk("R9 status", 64'(rv), 0);
    wr(0, 1, 32'h0);
  endtask

  task automatic t_levelmode;
    wr(0, 0, 32'h4);
    wr(4, 0, ~32'h4);
    @(negedge clk);
    lvl_pad[2] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 level sets irq", 64'(lvl_irq), 1);
    wr(5, 0, ~32'h4);
    rd(5, 0); chk("R10 re-set while high", 64'(lv), 64'h4);
    wr(6, 0, 32'hFFFF_FFFF);
    rd(6, 0); chk("R10 edge array absent", 64'(lv), 0);
    lvl_pad[2] = 1'b0;
    repeat (3) @(posedge clk);
    wr(5, 0, 32'h0);
    chk("R10 clear after low", 64'(lvl_irq), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_output;
    t_level;
    t_edges;
    t_blocked;
    t_spare;
    t_levelmode;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule